// File: doc/BRIEF.md
# Two-Wire LED String Serializer

This block drives a clocked addressable LED string over two lines, a clock line and a data line. It takes bytes one at a time on a valid/ready handshake, shifts each byte out bit by bit, and produces the line clock by dividing its own reference clock by 4, 8, 16 or 32. A byte can go out least significant bit first or most significant bit first. The host sets the order per byte, and the block captures it when it accepts the byte.

Transfer runs only while both the enable input and the start input are high. Dropping start lets the byte in flight finish and then parks the lines. Dropping enable abandons the byte at once. When a new byte is offered during the last bit of the current byte, it follows with no gap in the clock. This lets an upstream buffer feed a whole LED frame as one continuous stream. The completion output is high whenever no byte is in flight. Firmware can poll it to know that the last bit has left the block.

Top module: `led2w_serializer`

## Requirements
- R1: During reset and on the first cycle after it, led_clk and led_dat are 0 and tx_done is 1.
- R2: Each half period of led_clk lasts 2<<rate_sel reference cycles, using the rate captured when the byte was accepted from idle. rate_sel 00, 01, 10 and 11 give line clocks of the reference divided by 4, 8, 16 and 32. A bit is a low half followed by a high half.
- R3: With msb_first 0 the byte goes out from bit 0 up to bit 7. With msb_first 1 it goes from bit 7 down to bit 0. The order is the value of msb_first on the accepting cycle.
- R4: led_dat changes only while led_clk is low and holds its value for the whole high half period.
- R5: in_ready is high only when enable and start are both 1, and only when the block is idle or is in the final cycle of the high half of a byte's last bit.
- R6: A byte accepted during the last bit of the previous byte starts its low half directly, and tx_done stays 0 between the two bytes.
- R7: When start falls during a byte, that byte completes with all 8 bits. No further byte is accepted while start is 0.
- R8: When enable is 0 at a clock edge, the block is idle after that edge, with led_clk and led_dat at 0 and tx_done at 1.
- R9: While no byte is in flight, led_clk and led_dat are 0 and tx_done is 1. tx_done is 0 from the cycle after a byte is accepted until that byte or its back-to-back successors finish.
- R10: A change of rate_sel while a byte is in flight has no effect on the bit timing of that byte or of the bytes that follow it back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; 0 aborts any transfer |
| start | input | 1 | Output run control; 0 stops after the current byte |
| msb_first | input | 1 | Bit order for the next accepted byte, 1 = MSB first |
| rate_sel | input | 2 | Line clock division code (4, 8, 16, 32) |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Byte accepted this cycle when in_valid is also high |
| led_clk | output | 1 | Line clock, idles low |
| led_dat | output | 1 | Line data, idles low |
| tx_done | output | 1 | 1 when no byte is in flight |

## Verification
Single isolated bytes are sent at each of the four rate codes, in both bit orders. These show whether the half-period count and the order mux are right on their own, with no carry-over from a previous byte. A held-valid stream of four bytes shows whether the next byte is loaded during the last high half rather than after a return to idle. Mid-byte drops of start and of enable show a graceful finish apart from an abort. A rate change in the middle of a byte shows whether the rate is captured only from idle. A seeded random mix of data, order, rate and inter-byte gap then crosses all of these. A monitor rebuilds every bit and every half period from the lines.

// File: rtl/led2w_pkg.sv
package led2w_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } led2w_state_e;

endpackage

// File: rtl/led2w_halfdiv.sv
// Half-period timer: tick pulses at the last cycle of each half period.
module led2w_halfdiv #(
    parameter int RATE_W        = 2,
    parameter int HALF_MIN_LOG2 = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              clear,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    localparam int CODES = 1 << RATE_W;
    localparam int CNT_W = HALF_MIN_LOG2 + CODES - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_t;

    div_t div_d, div_q;

    logic [CNT_W-1:0] lim_tab [CODES];

    for (genvar g = 0; g < CODES; g++) begin : g_lim
        assign lim_tab[g] = CNT_W'((1 << (HALF_MIN_LOG2 + g)) - 1);
    end

    always_comb begin
        div_d = div_q;
        tick  = run && (div_q.cnt == lim_tab[rate]);
        if (clear || tick || !run) begin
            div_d.cnt = '0;
        end else begin
            div_d.cnt = div_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

endmodule

// File: rtl/led2w_shreg.sv
// Byte shift register with per-byte bit order.
module led2w_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] load_data,
    input  logic         load_msb,
    output logic         bit_o,
    output logic         last_o
);
    localparam int IDX_W = (W > 1) ? $clog2(W) : 1;

    typedef struct packed {
        logic [W-1:0]     data;
        logic [IDX_W-1:0] idx;
        logic             msb;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d.data = load_data;
            sh_d.idx  = '0;
            sh_d.msb  = load_msb;
        end else if (shift) begin
            sh_d.data = sh_q.msb ? (sh_q.data << 1) : (sh_q.data >> 1);
            sh_d.idx  = sh_q.idx + IDX_W'(1);
        end
    end

    assign bit_o  = sh_q.msb ? sh_q.data[W-1] : sh_q.data[0];
    assign last_o = (sh_q.idx == IDX_W'(W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

endmodule

// File: rtl/led2w_serializer.sv
module led2w_serializer #(
    parameter int DATA_W        = 8,
    parameter int RATE_W        = 2,
    parameter int HALF_MIN_LOG2 = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              start,
    input  logic              msb_first,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              led_clk,
    output logic              led_dat,
    output logic              tx_done
);
    import led2w_pkg::*;

    typedef struct packed {
        led2w_state_e      state;
        logic [RATE_W-1:0] rate;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic busy, tick, last_bit, cur_bit;
    logic accept, load, shift;
    logic [RATE_W-1:0] rate_cur;

    assign busy     = (ctl_q.state != ST_IDLE);
    assign rate_cur = ctl_q.rate;
    assign in_ready = enable && start &&
                      ((ctl_q.state == ST_IDLE) ||
                       ((ctl_q.state == ST_HIGH) && tick && last_bit));
    assign accept   = in_valid && in_ready;

    led2w_halfdiv #(
        .RATE_W       (RATE_W),
        .HALF_MIN_LOG2(HALF_MIN_LOG2)
    ) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .clear(accept),
        .rate (ctl_q.rate),
        .tick (tick)
    );

    led2w_shreg #(
        .W(DATA_W)
    ) u_sh (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .shift    (shift),
        .load_data(in_data),
        .load_msb (msb_first),
        .bit_o    (cur_bit),
        .last_o   (last_bit)
    );

    always_comb begin
        ctl_d = ctl_q;
        load  = accept;
        shift = 1'b0;
        if (ctl_q.state == ST_IDLE) begin
            ctl_d.rate = rate_sel;
        end
        case (ctl_q.state)
            ST_IDLE: begin
                if (accept) ctl_d.state = ST_LOW;
            end
            ST_LOW: begin
                if (tick) ctl_d.state = ST_HIGH;
            end
            ST_HIGH: begin
                if (tick) begin
                    if (!last_bit) begin
                        ctl_d.state = ST_LOW;
                        shift       = 1'b1;
                    end else if (accept) begin
                        ctl_d.state = ST_LOW;
                    end else begin
                        ctl_d.state = ST_IDLE;
                    end
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
        if (!enable) begin
            ctl_d.state = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, rate: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign led_clk = (ctl_q.state == ST_HIGH);
    assign led_dat = busy && cur_bit;
    assign tx_done = !busy;

endmodule

// File: rtl/led2w_serializer_chk.sv
module led2w_serializer_chk #(
    parameter int RATE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              start,
    input logic              in_valid,
    input logic              in_ready,
    input logic              led_clk,
    input logic              led_dat,
    input logic              tx_done,
    input logic [RATE_W-1:0] rate_cur
);
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> (!led_clk && !led_dat));

    a_r5_ready_gate: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (enable && start && (tx_done || led_clk)));

    a_r4_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (led_clk && $past(led_clk)) |-> $stable(led_dat));

    a_r8_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> tx_done);

    a_r6_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !tx_done) |=> !tx_done);

    a_r10_rate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_done && $past(!tx_done)) |-> $stable(rate_cur));

endmodule

bind led2w_serializer led2w_serializer_chk #(.RATE_W(RATE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .start   (start),
    .in_valid(in_valid),
    .in_ready(in_ready),
    .led_clk (led_clk),
    .led_dat (led_dat),
    .tx_done (tx_done),
    .rate_cur(rate_cur)
);

// File: tb/led2w_serializer_test.sv
`timescale 1ns/1ps
module led2w_serializer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       start = 1'b0;
    logic       msb_first = 1'b0;
    logic [1:0] rate_sel = 2'd0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'd0;
    logic       in_ready, led_clk, led_dat, tx_done;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    // monitor state
    bit   exp_q[$];
    int   h_exp = 2;
    int   lowcnt = 0;
    int   highcnt = 0;
    bit   prev_clk = 0;
    bit   captured = 0;
    int   accepts = 0;
    bit   abort_ok = 0;
    bit   stream_chk = 0;
    bit   gap_seen = 0;

    always #2 clk = ~clk;

    led2w_serializer uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
        .msb_first(msb_first), .rate_sel(rate_sel), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .led_clk(led_clk),
        .led_dat(led_dat), .tx_done(tx_done)
    );

    function automatic bit exp_bit(input logic [7:0] d, input int i, input bit msb);
        return msb ? d[7-i] : d[i];
    endfunction

    function automatic int half_of(input logic [1:0] r);
        return 2 << r;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // line monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (in_ready)
                check(enable && start && (tx_done || led_clk), "R5 ready gating", int'(in_ready), 0);
            if (!led_clk && prev_clk && !abort_ok)
                check(highcnt == h_exp, "R2/R10 high half length", highcnt, h_exp);
            if (tx_done) begin
                check(!led_clk && !led_dat, "R9 idle lines", int'({led_clk, led_dat}), 0);
                if (abort_ok) exp_q.delete();
                else check(exp_q.size() == 0, "R9 done with bits pending", exp_q.size(), 0);
                lowcnt = 0;
                highcnt = 0;
            end else if (led_clk) begin
                if (!prev_clk) begin
                    check(lowcnt == h_exp, "R2 low half length", lowcnt, h_exp);
                    lowcnt = 0;
                    captured = led_dat;
                    if (exp_q.size() > 0) begin
                        bit e;
                        e = exp_q.pop_front();
                        check(led_dat == e, "R3 bit value/order", int'(led_dat), int'(e));
                    end else begin
                        check(0, "R3 unexpected bit", 1, 0);
                    end
                    highcnt = 1;
                end else begin
                    highcnt++;
                    check(led_dat == captured, "R4 data stable in high", int'(led_dat), int'(captured));
                end
            end else begin
                if (prev_clk) highcnt = 0;
                lowcnt++;
            end
            if (in_valid && in_ready) begin
                if (tx_done) h_exp = half_of(rate_sel);
                for (int i = 0; i < 8; i++) exp_q.push_back(exp_bit(in_data, i, msb_first));
                accepts++;
            end
            prev_clk = led_clk;
        end
    end

    task automatic put(input logic [7:0] d, input bit msb, input logic [1:0] r);
        in_data = d;
        msb_first = msb;
        rate_sel = r;
        in_valid = 1'b1;
        do begin
            @(negedge clk);
            if (stream_chk && tx_done) gap_seen = 1;
        end while (!in_ready);
        @(posedge clk);
        #1;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!tx_done);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        report();
    end

    initial begin
        int k;
        int acc0;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check(!led_clk && !led_dat && tx_done, "R1 in reset", int'({led_clk, led_dat, tx_done}), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(!led_clk && !led_dat && tx_done, "R1 after reset", int'({led_clk, led_dat, tx_done}), 1);
        enable = 1'b1;
        start = 1'b1;
        @(negedge clk);

        // single bytes at all four rates, both orders (R2, R3)
        for (int r = 0; r < 4; r++) begin
            put(8'hA5 ^ 8'(r * 17), r[0], 2'(r));
            in_valid = 1'b0;
            wait_idle();
            put(8'h3C + 8'(r), ~r[0], 2'(r));
            in_valid = 1'b0;
            wait_idle();
        end

        // R6: back-to-back stream with valid held
        gap_seen = 0;
        put(8'h81, 1'b1, 2'd1);
        stream_chk = 1;
        put(8'h7E, 1'b0, 2'd1);
        put(8'hC3, 1'b1, 2'd3);
        put(8'h18, 1'b0, 2'd0);
        stream_chk = 0;
        in_valid = 1'b0;
        check(gap_seen == 0, "R6 no gap in stream", int'(gap_seen), 0);
        wait_idle();

        // R7: start dropped mid-byte, next byte pending
        put(8'hE7, 1'b0, 2'd1);
        in_data = 8'h55;
        acc0 = accepts;
        repeat (10) @(negedge clk);
        start = 1'b0;
        wait_idle();
        check(accepts == acc0, "R7 no accept after stop", accepts, acc0);
        k = 0;
        repeat (40) begin
            @(negedge clk);
            if (!tx_done) k++;
        end
        check(k == 0 && accepts == acc0, "R7 stays idle while stopped", k, 0);
        in_valid = 1'b0;
        start = 1'b1;
        @(negedge clk);

        // R8: enable dropped mid-byte aborts
        put(8'hF0, 1'b1, 2'd2);
        in_valid = 1'b0;
        repeat (20) @(negedge clk);
        @(posedge clk);
        #1;
        enable = 1'b0;
        abort_ok = 1;
        @(posedge clk);
        @(negedge clk);
        check(tx_done && !led_clk && !led_dat, "R8 abort to idle", int'({tx_done, led_clk, led_dat}), 4);
        @(posedge clk);
        #1;
        abort_ok = 0;
        enable = 1'b1;
        @(negedge clk);

        // R10: rate change mid-byte ignored; byte at rate 0 lasts 32 cycles
        put(8'h96, 1'b0, 2'd0);
        in_valid = 1'b0;
        k = 0;
        do begin
            @(negedge clk);
            if (!tx_done) k++;
            if (k == 5) rate_sel = 2'd3;
        end while (!tx_done);
        check(k == 32, "R10 byte length unchanged", k, 32);

        // constrained random mix
        for (int n = 0; n < 40; n++) begin
            put(8'($urandom), 1'($urandom % 2), 2'($urandom % 4));
            if ($urandom % 3 != 0) begin
                in_valid = 1'b0;
                repeat ($urandom % 5) @(negedge clk);
            end
        end
        in_valid = 1'b0;
        wait_idle();
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R9 all bits delivered", exp_q.size(), 0);
        report();
    end
endmodule